// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus on which a target is stuck holding SDA low, typically after a transfer was cut off mid-byte. Software writes a configuration word (enable, terminate mode, optional STOP, pulse limit) into a shadow register. It then issues a load request. The settings move into the active copy only while the sequencer is idle. With the active enable set, the block toggles SCL through its open-drain driver, one phase per tick from the shared bit-clock divider, and samples SDA at the end of every high phase.

There are two terminate modes. In immediate mode the run stops at the first pulse whose high phase sees SDA released. In threshold mode all programmed pulses are always issued. Either mode can finish with a STOP condition. At the end the block records whether SDA was last seen high, sets a sticky write-1-to-clear completion flag, and clears the enable bit.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, SCL and SDA are not driven (`scl_oe_o`=0, `sda_oe_o`=0), `busy_o`=0, `load_pending_o`=0, and `cfg_rdata_o`, `irq_status_o` and `status_o` all read zero.
- R2: A configuration write alone starts nothing. A pulse on `cfg_load_i` sets `load_pending_o`. The shadow settings are copied to the active copy, and `load_pending_o` is cleared, only while `busy_o`=0. A load requested during a run stays pending until that run ends.
- R3: Configuration word layout: bit 0 enable, bit 1 terminate mode (1 = immediate, 0 = threshold), bit 2 STOP at end, bits 23:16 pulse limit. Each SCL pulse is SCL driven low for one tick interval, then released for one tick interval. SCL is released only in the cycle after a tick, and SDA is not driven during pulses.
- R4: In threshold mode exactly `limit` pulses are issued whatever SDA does. A limit of 9 is supported, and a limit of 0 is treated as 1.
- R5: In immediate mode the run ends after the first pulse whose high-phase sample sees SDA high. It never issues more than the limit.
- R6: With the STOP bit set, the end of the run first holds SCL low and then drives SDA low while SCL stays low. It then releases SCL and finally releases SDA. With the STOP bit clear, SDA is never driven.
- R7: Completion sets bit 11 of `irq_status_o`. The bit stays set until a write on `irq_wr_i` with bit 11 of `irq_wdata_i` at 1. A write with bit 11 at 0 leaves it set.
- R8: Bit 0 of `status_o` holds the SDA level sampled at the end of the last pulse of the most recent run.
- R9: When a run finishes, the enable bit (bit 0 of `cfg_rdata_o`) clears itself. No new run starts until software enables and loads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Phase tick from the shared bit-clock divider |
| cfg_we_i | input | 1 | Write strobe for the shadow configuration |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_load_i | input | 1 | Request to move shadow settings to the active copy |
| irq_wr_i | input | 1 | Write strobe for the interrupt status |
| irq_wdata_i | input | 32 | Interrupt status write data, 1 clears |
| sda_i | input | 1 | Sampled SDA line level |
| cfg_rdata_o | output | 32 | Shadow configuration readback |
| load_pending_o | output | 1 | Load requested but not yet applied |
| irq_status_o | output | 32 | Interrupt status, bit 11 = clear done |
| status_o | output | 32 | Bus-clear status, bit 0 = SDA freed |
| busy_o | output | 1 | Sequence in progress |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The bench models a target that lets go of SDA after a chosen number of pulses, or never. It counts SCL releases to catch off-by-one pulse counts: a design that compared the count before incrementing it would emit one pulse too many or too few. A design that ignored the terminate mode would run to the limit where it should stop early. The zero limit and an SDA line that is already high at the first sample are both exercised, as are the STOP ordering, a flag that is not truly sticky or that clears on a write of 0, and a load request honoured in the middle of a run.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_TERM_BIT = 1;
  localparam int unsigned CFG_STOP_BIT = 2;
  localparam int unsigned CFG_THR_LSB  = 16;
  localparam int unsigned IRQ_DONE_BIT = 11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_SP_HOLD, ST_SP_SDA, ST_SP_SCL, ST_DONE
  } bc_state_e;
endpackage

// File: rtl/bc_cfg_regs.sv
module bc_cfg_regs #(
  parameter int unsigned DW    = 32,
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             load_i,
  input  logic             eng_busy_i,
  input  logic             eng_done_i,
  output logic [DW-1:0]    rdata_o,
  output logic             pending_o,
  output logic             act_en_o,
  output logic             act_term_o,
  output logic             act_stop_o,
  output logic [THR_W-1:0] act_thr_o
);
  import bc_pkg::*;

  logic [DW-1:0] shadow_q;
  logic          pending_q;
  logic          copy;

  assign copy = pending_q && !eng_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (we_i) begin
      shadow_q <= wdata_i;
    end else if (eng_done_i) begin
      shadow_q[CFG_EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
    end else if (load_i) begin
      pending_q <= 1'b1;
    end else if (copy) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_o   <= 1'b0;
      act_term_o <= 1'b0;
      act_stop_o <= 1'b0;
      act_thr_o  <= '0;
    end else if (copy) begin
      act_en_o   <= shadow_q[CFG_EN_BIT];
      act_term_o <= shadow_q[CFG_TERM_BIT];
      act_stop_o <= shadow_q[CFG_STOP_BIT];
      act_thr_o  <= shadow_q[CFG_THR_LSB +: THR_W];
    end else if (eng_done_i) begin
      act_en_o   <= 1'b0;
    end
  end

  assign rdata_o   = shadow_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/bc_engine.sv
module bc_engine #(
  parameter int unsigned THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             stop_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             freed_o
);
  import bc_pkg::*;

  localparam int unsigned CW = THR_W + 1;

  bc_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d, cnt_nx, thr_eff;
  logic           freed_q, freed_d;
  logic           finish;

  // limit of zero behaves as one pulse
  assign thr_eff = (thr_i == '0) ? CW'(1) : CW'(thr_i);
  assign cnt_nx  = cnt_q + CW'(1);
  assign finish  = (term_i && sda_i) || (cnt_nx >= thr_eff);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    freed_d = freed_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_LOW;
        cnt_d = '0;
      end
      ST_LOW:  if (tick_i) st_d = ST_HIGH;
      ST_HIGH: if (tick_i) begin
        cnt_d   = cnt_nx;
        freed_d = sda_i;
        if (finish) st_d = stop_i ? ST_SP_HOLD : ST_DONE;
        else        st_d = ST_LOW;
      end
      ST_SP_HOLD: if (tick_i) st_d = ST_SP_SDA;
      ST_SP_SDA:  if (tick_i) st_d = ST_SP_SCL;
      ST_SP_SCL:  if (tick_i) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      freed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      freed_q <= freed_d;
    end
  end

  assign scl_oe_o = (st_q == ST_LOW) || (st_q == ST_SP_HOLD) || (st_q == ST_SP_SDA);
  assign sda_oe_o = (st_q == ST_SP_SDA) || (st_q == ST_SP_SCL);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_DONE);
  assign freed_o  = freed_q;
endmodule

// File: rtl/bc_status.sv
module bc_status #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          freed_i,
  input  logic          irq_wr_i,
  input  logic [DW-1:0] irq_wdata_i,
  output logic [DW-1:0] irq_status_o,
  output logic [DW-1:0] status_o
);
  import bc_pkg::*;

  logic irq_q, freed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      freed_q <= 1'b0;
    end else begin
      // completion wins over a simultaneous clear
      if (done_i) irq_q <= 1'b1;
      else if (irq_wr_i && irq_wdata_i[IRQ_DONE_BIT]) irq_q <= 1'b0;
      if (done_i) freed_q <= freed_i;
    end
  end

  always_comb begin
    irq_status_o = '0;
    irq_status_o[IRQ_DONE_BIT] = irq_q;
    status_o = '0;
    status_o[0] = freed_q;
  end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int unsigned DW    = 32,
  parameter int unsigned THR_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cfg_we_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          cfg_load_i,
  input  logic          irq_wr_i,
  input  logic [DW-1:0] irq_wdata_i,
  input  logic          sda_i,
  output logic [DW-1:0] cfg_rdata_o,
  output logic          load_pending_o,
  output logic [DW-1:0] irq_status_o,
  output logic [DW-1:0] status_o,
  output logic          busy_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  logic             act_en, act_term, act_stop;
  logic [THR_W-1:0] act_thr;
  logic             eng_done, eng_freed, eng_start;

  assign eng_start = act_en && !busy_o;

  bc_cfg_regs #(.DW(DW), .THR_W(THR_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .load_i     (cfg_load_i),
    .eng_busy_i (busy_o),
    .eng_done_i (eng_done),
    .rdata_o    (cfg_rdata_o),
    .pending_o  (load_pending_o),
    .act_en_o   (act_en),
    .act_term_o (act_term),
    .act_stop_o (act_stop),
    .act_thr_o  (act_thr)
  );

  bc_engine #(.THR_W(THR_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (eng_start),
    .term_i   (act_term),
    .stop_i   (act_stop),
    .thr_i    (act_thr),
    .sda_i    (sda_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o),
    .done_o   (eng_done),
    .freed_o  (eng_freed)
  );

  bc_status #(.DW(DW)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (eng_done),
    .freed_i      (eng_freed),
    .irq_wr_i     (irq_wr_i),
    .irq_wdata_i  (irq_wdata_i),
    .irq_status_o (irq_status_o),
    .status_o     (status_o)
  );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          irq_wr_i,
  input logic [DW-1:0] irq_wdata_i,
  input logic [DW-1:0] cfg_rdata_o,
  input logic          load_pending_o,
  input logic [DW-1:0] irq_status_o,
  input logic          busy_o,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic          eng_done
);
  p_scl_release_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> $past(tick_i));

  p_sda_only_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> busy_o);

  p_stop_sda_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> scl_oe_o && $past(scl_oe_o));

  p_stop_sda_rel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o);

  p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> irq_status_o[11]);

  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_status_o[11] && !(irq_wr_i && irq_wdata_i[11]) |=> irq_status_o[11]);

  p_load_waits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pending_o && busy_o |=> load_pending_o);

  p_en_selfclr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !cfg_rdata_o[0]);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .irq_wr_i       (irq_wr_i),
  .irq_wdata_i    (irq_wdata_i),
  .cfg_rdata_o    (cfg_rdata_o),
  .load_pending_o (load_pending_o),
  .irq_status_o   (irq_status_o),
  .busy_o         (busy_o),
  .scl_oe_o       (scl_oe_o),
  .sda_oe_o       (sda_oe_o),
  .eng_done       (eng_done)
);

// File: tb/i2c_bus_recover_bench.sv
`timescale 1ns/1ps
module i2c_bus_recover_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        cfg_load_i = 1'b0;
  logic        irq_wr_i = 1'b0;
  logic [31:0] irq_wdata_i = '0;
  logic        sda_i;
  logic [31:0] cfg_rdata_o, irq_status_o, status_o;
  logic        load_pending_o, busy_o, scl_oe_o, sda_oe_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int scl_drives = 0;
  int rel_k = 255;
  bit prev_scl = 1'b0, prev_sda = 1'b0, stop_armed = 1'b0, stop_seen = 1'b0;
  int tdiv = 0;

  always #2 clk_i = ~clk_i;

  i2c_bus_recover u_i2c_bus_recover (.*);

  // target lets go of SDA once rel_k pulses have been released (255 = never)
  assign sda_i = !sda_oe_o && (rel_k != 255) && (pulses >= rel_k);

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv + 1) % 4;
    tick_i <= (tdiv == 3);
    prev_scl <= scl_oe_o;
    prev_sda <= sda_oe_o;
    if (prev_scl && !scl_oe_o && !sda_oe_o) pulses <= pulses + 1;
    if (!prev_scl && scl_oe_o) scl_drives <= scl_drives + 1;
    if (!prev_sda && sda_oe_o && scl_oe_o && prev_scl) stop_armed <= 1'b1;
    if (prev_sda && !sda_oe_o && !scl_oe_o && stop_armed) stop_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk_i); cfg_load_i = 1'b1;
    @(negedge clk_i); cfg_load_i = 1'b0;
  endtask

  task automatic w1c(input logic [31:0] v);
    @(negedge clk_i); irq_wr_i = 1'b1; irq_wdata_i = v;
    @(negedge clk_i); irq_wr_i = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int t = 0;
    while (!irq_status_o[11] && t < 5000) begin
      @(negedge clk_i); t++;
    end
    chk(irq_status_o[11], req, "done flag timeout", irq_status_o[11], 1);
  endtask

  task automatic clear_mon();
    @(negedge clk_i);
    pulses = 0; stop_armed = 1'b0; stop_seen = 1'b0; scl_drives = 0;
  endtask

  // vector: [31:24] limit, [23:16] release after, [15:8] exp pulses, [2] exp freed, [1] stop, [0] immediate
  localparam logic [31:0] VEC [7] = '{
    {8'd9, 8'd3,   8'd3, 5'd0, 1'b1, 1'b0, 1'b1},
    {8'd9, 8'd3,   8'd9, 5'd0, 1'b1, 1'b0, 1'b0},
    {8'd9, 8'd255, 8'd9, 5'd0, 1'b0, 1'b0, 1'b1},
    {8'd9, 8'd1,   8'd1, 5'd0, 1'b1, 1'b1, 1'b1},
    {8'd4, 8'd255, 8'd4, 5'd0, 1'b0, 1'b1, 1'b0},
    {8'd0, 8'd255, 8'd1, 5'd0, 1'b0, 1'b0, 1'b0},
    {8'd2, 8'd0,   8'd1, 5'd0, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!scl_oe_o && !sda_oe_o && !busy_o, "R1", "lines/busy in reset", {scl_oe_o, sda_oe_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cfg_rdata_o == 0 && irq_status_o == 0 && status_o == 0 && !load_pending_o,
        "R1", "registers after reset", cfg_rdata_o | irq_status_o | status_o, 0);

    // R2: write without load starts nothing
    clear_mon();
    wr_cfg(32'h0009_0001);
    repeat (40) @(negedge clk_i);
    chk(!busy_o && scl_drives == 0, "R2", "run without load", scl_drives, 0);
    chk(cfg_rdata_o == 32'h0009_0001, "R2", "shadow readback", cfg_rdata_o, 32'h0009_0001);
    w1c(32'h0);

    for (int i = 0; i < 7; i++) begin
      logic [31:0] v = VEC[i];
      clear_mon();
      rel_k = int'(v[23:16]);
      wr_cfg({8'h0, v[31:24], 13'h0, v[1], v[0], 1'b1});
      do_load();
      wait_irq("R7");
      repeat (2) @(negedge clk_i);
      chk(pulses == int'(v[15:8]), v[0] ? "R5" : "R4", $sformatf("pulses vec %0d", i), pulses, int'(v[15:8]));
      chk(status_o[0] == v[2], "R8", $sformatf("freed vec %0d", i), status_o[0], v[2]);
      chk(stop_seen == v[1], "R6", $sformatf("stop vec %0d", i), stop_seen, v[1]);
      chk(!cfg_rdata_o[0] && !busy_o, "R9", $sformatf("enable self-clear vec %0d", i), cfg_rdata_o[0], 0);
      w1c(32'h0000_0800);
    end

    // R9: no second run without re-enable
    clear_mon();
    do_load();
    repeat (40) @(negedge clk_i);
    chk(scl_drives == 0 && !busy_o, "R9", "restart after self-clear", scl_drives, 0);

    // R7: sticky, write of 0 keeps it, write of 1 clears
    rel_k = 255;
    wr_cfg(32'h0002_0001);
    do_load();
    wait_irq("R7");
    repeat (20) @(negedge clk_i);
    chk(irq_status_o[11], "R7", "flag sticky", irq_status_o[11], 1);
    w1c(32'hFFFF_F7FF);
    chk(irq_status_o[11], "R7", "write 0 keeps flag", irq_status_o[11], 1);
    w1c(32'h0000_0800);
    chk(!irq_status_o[11], "R7", "write 1 clears flag", irq_status_o[11], 0);

    // R2: load during a run is deferred
    clear_mon();
    rel_k = 255;
    wr_cfg(32'h0009_0001);
    do_load();
    repeat (10) @(negedge clk_i);
    wr_cfg(32'h0005_0000);
    do_load();
    chk(busy_o && load_pending_o, "R2", "load pending while busy", load_pending_o, 1);
    repeat (20) @(negedge clk_i);
    chk(load_pending_o, "R2", "still pending mid-run", load_pending_o, 1);
    wait_irq("R2");
    repeat (3) @(negedge clk_i);
    chk(!load_pending_o, "R2", "pending cleared after run", load_pending_o, 0);
    chk(pulses == 9, "R4", "deferred load kept limit", pulses, 9);
    repeat (30) @(negedge clk_i);
    chk(!busy_o, "R2", "disabled load starts nothing", busy_o, 0);
    w1c(32'h0000_0800);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule